// File: doc/BRIEF.md
# MMU Context and Bypass Selector

This block sits in front of a translation lookaside buffer and settles, for every translation request, how the request will be handled. It reads a packed 64-bit processor-state word together with a bit saying whether the request fetches an instruction or accesses data. It also reads four address-space class flags: implicit/primary, secondary, nucleus and real. From these it produces four decisions. The first is whether translation is skipped, and if so the physical address to use. The second is whether the lookup uses real addresses. The third is which context number tags the lookup, and the fourth is what kind of context that is. The partition number is passed along for the lookup array.

The decision follows a fixed order. Hypervisor or red-state mode comes first. Next, context zero is forced by a raised trap level or a nucleus-class access. After that comes the choice between secondary and primary, and real mode is forced last. An optional register stage, on by default, holds every output for one cycle so the result lines up with a pipelined lookup.

Top module: `mmu_ctx_sel`

## Requirements
- R1: The state word is decoded as: bit 0 hypervisor, bit 1 red state, bit 2 privileged, bit 3 address mask, bit 4 instruction translation enable, bit 5 data translation enable, bits [15:8] partition, bits [18:16] trap level, bits [47:32] primary context; the secondary context is read from the same bits [47:32].
- R2: An instruction request (`is_data`=0) with hypervisor or red state set raises `bypass`, clears `real_mode`, and drives `phys_addr` with `vaddr` ANDed with a mask of the low `PA_BITS` bits (40 by default).
- R3: An instruction request that is not bypassed and has instruction translation enable clear gives `real_mode`=1, `ctx`=0 and `ctx_kind`=0.
- R4: An instruction request that is not bypassed and has instruction translation enable set gives `real_mode`=0, `ctx` equal to the primary context and `ctx_kind`=0 (primary).
- R5: A data request with neither hypervisor nor red state set, and with trap level above zero or the nucleus flag set, gives `ctx_kind`=2 (nucleus) and `ctx`=0; this wins over the secondary flag.
- R6: Otherwise a data request with neither hypervisor nor red state gives `ctx_kind`=1 (secondary) with the secondary context when the secondary flag is set, and `ctx_kind`=0 with the primary context when it is not. `ctx_kind` never takes the value 3.
- R7: A data request never raises `bypass`. It is real (`real_mode`=1, `ctx`=0, `ctx_kind` kept from R5, R6 or R8) when data translation enable is clear without hypervisor, or when the real flag is set.
- R8: A data request with hypervisor or red state set uses `ctx_kind`=0 and the primary context, ignoring trap level, nucleus and secondary flags.
- R9: `part_id` always equals state bits [15:8], whatever the bypass or real decision.
- R10: With `OUT_REG`=1 every output reflects the inputs presented one clock edge earlier; a synchronous active-high reset clears every output to zero.
- R11: An instruction request is unaffected by the four class flags and by the data translation enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| is_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| state_word | input | 64 | Packed processor-state word |
| vaddr | input | 64 | Virtual address of the request |
| asi_primary | input | 1 | Implicit/primary class flag |
| asi_secondary | input | 1 | Secondary class flag |
| asi_nucleus | input | 1 | Nucleus class flag |
| asi_real | input | 1 | Real class flag |
| bypass | output | 1 | Translation skipped |
| phys_addr | output | 64 | Masked address used when bypassing |
| real_mode | output | 1 | Lookup uses real addresses |
| ctx | output | 16 | Context number for the lookup |
| ctx_kind | output | 2 | 0 primary, 1 secondary, 2 nucleus |
| part_id | output | 8 | Partition number |

## Verification
Two rules overlap in a data request whose trap level is raised while hypervisor or red state is also set, or that combines a real-class flag with a secondary or nucleus flag. These cases are the hardest to reach because several rules then compete. The directed tasks build state words that set several of these conditions at once. They check that the mode override beats trap level, that real forcing clears the context while keeping the kind, and that the instruction path ignores the class flags even when all of them are raised.

// File: rtl/mmu_sel_pkg.sv
package mmu_sel_pkg;

    localparam int WORD_W = 64;
    localparam int CTX_W  = 16;
    localparam int PART_W = 8;
    localparam int TL_W   = 3;

    // bit positions inside the packed state word
    localparam int POS_HV    = 0;
    localparam int POS_RED   = 1;
    localparam int POS_PRIV  = 2;
    localparam int POS_AMASK = 3;
    localparam int POS_IEN   = 4;
    localparam int POS_DEN   = 5;
    localparam int POS_PART  = 8;
    localparam int POS_TL    = 16;
    localparam int POS_CTX   = 32;

    typedef enum logic [1:0] {
        KIND_PRIMARY   = 2'd0,
        KIND_SECONDARY = 2'd1,
        KIND_NUCLEUS   = 2'd2
    } ctx_kind_e;

    typedef struct packed {
        logic              hv;
        logic              red;
        logic              priv;
        logic              amask;
        logic              imu_on;
        logic              dmu_on;
        logic [PART_W-1:0] part;
        logic [TL_W-1:0]   tl;
        logic [CTX_W-1:0]  pctx;
        logic [CTX_W-1:0]  sctx;
    } state_fields_t;

    typedef struct packed {
        logic              prim;
        logic              sec;
        logic              nuc;
        logic              rl;
    } asi_class_t;

    typedef struct packed {
        logic              bypass;
        logic [WORD_W-1:0] paddr;
        logic              real_m;
        logic [CTX_W-1:0]  ctx;
        ctx_kind_e         kind;
        logic [PART_W-1:0] part;
    } sel_out_t;

    function automatic logic [WORD_W-1:0] pa_mask(input int bits_n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < bits_n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mmu_state_unpack.sv
module mmu_state_unpack
    import mmu_sel_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output state_fields_t     fields
);
    always_comb begin
        fields.hv     = word[POS_HV];
        fields.red    = word[POS_RED];
        fields.priv   = word[POS_PRIV];
        fields.amask  = word[POS_AMASK];
        fields.imu_on = word[POS_IEN];
        fields.dmu_on = word[POS_DEN];
        fields.part   = word[POS_PART +: PART_W];
        fields.tl     = word[POS_TL +: TL_W];
        fields.pctx   = word[POS_CTX +: CTX_W];
        // secondary context shares the primary field
        fields.sctx   = word[POS_CTX +: CTX_W];
    end
endmodule

// File: rtl/mmu_ctx_pick.sv
module mmu_ctx_pick
    import mmu_sel_pkg::*;
#(
    parameter int PA_BITS = 40
) (
    input  state_fields_t     fields,
    input  logic              is_data,
    input  asi_class_t        asi,
    input  logic [WORD_W-1:0] vaddr,
    output sel_out_t          res
);
    localparam logic [WORD_W-1:0] MASK = pa_mask(PA_BITS);

    logic mode_over;
    logic force_zero;

    always_comb begin
        mode_over  = fields.hv | fields.red;
        force_zero = (fields.tl != '0) | asi.nuc;

        res.paddr  = vaddr & MASK;
        res.part   = fields.part;
        res.bypass = 1'b0;
        res.real_m = 1'b0;
        res.ctx    = fields.pctx;
        res.kind   = KIND_PRIMARY;

        if (!is_data) begin
            if (mode_over) begin
                res.bypass = 1'b1;
            end else if (!fields.imu_on) begin
                res.real_m = 1'b1;
                res.ctx    = '0;
            end
        end else begin
            if (!mode_over) begin
                if (force_zero) begin
                    res.kind = KIND_NUCLEUS;
                    res.ctx  = '0;
                end else if (asi.sec) begin
                    res.kind = KIND_SECONDARY;
                    res.ctx  = fields.sctx;
                end
            end
            if ((!fields.dmu_on && !fields.hv) || asi.rl) begin
                res.real_m = 1'b1;
                res.ctx    = '0;
            end
        end
    end
endmodule

// File: rtl/mmu_out_stage.sv
module mmu_out_stage
    import mmu_sel_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  sel_out_t d,
    output sel_out_t q
);
    generate
        if (OUT_REG) begin : g_reg
            sel_out_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel
    import mmu_sel_pkg::*;
#(
    parameter int PA_BITS = 40,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_data,
    input  logic [63:0]       state_word,
    input  logic [63:0]       vaddr,
    input  logic              asi_primary,
    input  logic              asi_secondary,
    input  logic              asi_nucleus,
    input  logic              asi_real,
    output logic              bypass,
    output logic [63:0]       phys_addr,
    output logic              real_mode,
    output logic [15:0]       ctx,
    output logic [1:0]        ctx_kind,
    output logic [7:0]        part_id
);
    localparam logic [63:0] CHK_MASK = pa_mask(PA_BITS);

    state_fields_t fields;
    asi_class_t    asi;
    sel_out_t      pick;
    sel_out_t      held;

    assign asi = '{prim: asi_primary, sec: asi_secondary,
                   nuc: asi_nucleus, rl: asi_real};

    mmu_state_unpack u_unpack (
        .word   (state_word),
        .fields (fields)
    );

    mmu_ctx_pick #(.PA_BITS(PA_BITS)) u_pick (
        .fields  (fields),
        .is_data (is_data),
        .asi     (asi),
        .vaddr   (vaddr),
        .res     (pick)
    );

    mmu_out_stage #(.OUT_REG(OUT_REG)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (pick),
        .q   (held)
    );

    assign bypass    = held.bypass;
    assign phys_addr = held.paddr;
    assign real_mode = held.real_m;
    assign ctx       = held.ctx;
    assign ctx_kind  = held.kind;
    assign part_id   = held.part;

    generate
        if (OUT_REG) begin : g_chk
            assert_instr_bypass_R2: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(!is_data && (state_word[0] || state_word[1])))
                |-> (bypass && !real_mode && phys_addr == ($past(vaddr) & CHK_MASK)));

            assert_instr_real_R3: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(!is_data && !state_word[0] && !state_word[1] && !state_word[4]))
                |-> (real_mode && ctx == 16'd0 && ctx_kind == 2'd0));

            assert_nucleus_R5: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(is_data && !state_word[0] && !state_word[1]
                                      && (state_word[18:16] != 3'd0 || asi_nucleus)))
                |-> (ctx_kind == 2'd2 && ctx == 16'd0));

            assert_kind_legal_R6: assert property (@(posedge clk) disable iff (rst)
                ctx_kind != 2'd3);

            assert_data_real_R7: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(is_data))
                |-> (!bypass && (($past(asi_real) || (!$past(state_word[5]) && !$past(state_word[0])))
                                 == real_mode)));

            assert_part_id_R9: assert property (@(posedge clk) disable iff (rst)
                $past(!rst) |-> (part_id == $past(state_word[15:8])));
        end
    endgenerate
endmodule

// File: tb/mmu_ctx_sel_bench.sv
module mmu_ctx_sel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        is_data = 1'b0;
    logic [63:0] state_word = '0;
    logic [63:0] vaddr = '0;
    logic        asi_primary = 1'b0;
    logic        asi_secondary = 1'b0;
    logic        asi_nucleus = 1'b0;
    logic        asi_real = 1'b0;
    logic        bypass;
    logic [63:0] phys_addr;
    logic        real_mode;
    logic [15:0] ctx;
    logic [1:0]  ctx_kind;
    logic [7:0]  part_id;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mmu_ctx_sel u_mmu_ctx_sel (
        .clk(clk), .rst(rst), .is_data(is_data), .state_word(state_word),
        .vaddr(vaddr), .asi_primary(asi_primary), .asi_secondary(asi_secondary),
        .asi_nucleus(asi_nucleus), .asi_real(asi_real), .bypass(bypass),
        .phys_addr(phys_addr), .real_mode(real_mode), .ctx(ctx),
        .ctx_kind(ctx_kind), .part_id(part_id)
    );

    function automatic logic [63:0] mk(input logic hv, input logic red,
                                       input logic ien, input logic den,
                                       input logic [7:0] part, input logic [2:0] tl,
                                       input logic [15:0] pc);
        logic [63:0] w;
        w = 64'hFFFF_0000_FFF8_00CC; // noise in unused bits, priv and amask set
        w[0] = hv; w[1] = red; w[4] = ien; w[5] = den;
        w[15:8] = part; w[18:16] = tl; w[47:32] = pc;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic d, input logic [63:0] w, input logic [63:0] va,
                         input logic p, input logic s, input logic n, input logic r);
        @(negedge clk);
        is_data = d; state_word = w; vaddr = va;
        asi_primary = p; asi_secondary = s; asi_nucleus = n; asi_real = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 reset bypass", {63'd0, bypass}, 64'd0);
        chk("R10 reset paddr", phys_addr, 64'd0);
        chk("R10 reset ctx", {48'd0, ctx}, 64'd0);
        chk("R10 reset part", {56'd0, part_id}, 64'd0);
    endtask

    task automatic t_instr_bypass;
        apply(0, mk(1, 0, 1, 1, 8'h3C, 0, 16'hBEEF), 64'hFFFF_FF12_3456_789A, 1, 1, 1, 1);
        chk("R2 hv bypass", {63'd0, bypass}, 64'd1);
        chk("R2 hv paddr", phys_addr, 64'h0000_0012_3456_789A);
        chk("R2 hv real", {63'd0, real_mode}, 64'd0);
        chk("R9 part on bypass", {56'd0, part_id}, 64'h3C);
        apply(0, mk(0, 1, 0, 0, 8'h01, 5, 16'h0001), 64'h8000_00FF_FFFF_FFFF, 0, 0, 0, 0);
        chk("R2 red bypass", {63'd0, bypass}, 64'd1);
        chk("R2 red paddr", phys_addr, 64'h0000_00FF_FFFF_FFFF);
    endtask

    task automatic t_instr_real;
        apply(0, mk(0, 0, 0, 1, 8'h77, 0, 16'h1234), 64'h1000, 0, 1, 0, 0);
        chk("R3 real", {63'd0, real_mode}, 64'd1);
        chk("R3 ctx zero", {48'd0, ctx}, 64'd0);
        chk("R3 kind", {62'd0, ctx_kind}, 64'd0);
        chk("R3 no bypass", {63'd0, bypass}, 64'd0);
    endtask

    task automatic t_instr_mapped;
        apply(0, mk(0, 0, 1, 0, 8'hA5, 3'd6, 16'hCAFE), 64'h2000, 1, 1, 1, 1);
        chk("R11 flags ignored real", {63'd0, real_mode}, 64'd0);
        chk("R4 R1 ctx primary", {48'd0, ctx}, 64'hCAFE);
        chk("R11 kind primary", {62'd0, ctx_kind}, 64'd0);
        chk("R1 R9 part", {56'd0, part_id}, 64'hA5);
    endtask

    task automatic t_data_nucleus;
        apply(1, mk(0, 0, 0, 1, 8'h10, 3'd2, 16'h4444), 64'h0, 0, 1, 0, 0);
        chk("R5 tl kind", {62'd0, ctx_kind}, 64'd2);
        chk("R5 tl ctx", {48'd0, ctx}, 64'd0);
        apply(1, mk(0, 0, 0, 1, 8'h10, 3'd0, 16'h4444), 64'h0, 0, 1, 1, 0);
        chk("R5 nucleus kind", {62'd0, ctx_kind}, 64'd2);
        chk("R5 nucleus no real", {63'd0, real_mode}, 64'd0);
    endtask

    task automatic t_data_sel;
        apply(1, mk(0, 0, 0, 1, 8'h20, 3'd0, 16'h5A5A), 64'h0, 0, 1, 0, 0);
        chk("R6 sec kind", {62'd0, ctx_kind}, 64'd1);
        chk("R6 sec ctx", {48'd0, ctx}, 64'h5A5A);
        apply(1, mk(0, 0, 0, 1, 8'h20, 3'd0, 16'h6B6B), 64'h0, 1, 0, 0, 0);
        chk("R6 pri kind", {62'd0, ctx_kind}, 64'd0);
        chk("R6 pri ctx", {48'd0, ctx}, 64'h6B6B);
    endtask

    task automatic t_data_real;
        apply(1, mk(0, 0, 1, 0, 8'h30, 3'd0, 16'h7777), 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 0);
        chk("R7 den off real", {63'd0, real_mode}, 64'd1);
        chk("R7 den off ctx", {48'd0, ctx}, 64'd0);
        chk("R7 kind kept", {62'd0, ctx_kind}, 64'd1);
        chk("R7 no bypass", {63'd0, bypass}, 64'd0);
        apply(1, mk(0, 0, 0, 1, 8'h30, 3'd0, 16'h7777), 64'h0, 1, 0, 0, 1);
        chk("R7 asi real", {63'd0, real_mode}, 64'd1);
        chk("R7 asi real ctx", {48'd0, ctx}, 64'd0);
        apply(1, mk(1, 0, 0, 0, 8'h30, 3'd0, 16'h7777), 64'h0, 1, 0, 0, 0);
        chk("R7 hv blocks real", {63'd0, real_mode}, 64'd0);
        chk("R7 hv no bypass", {63'd0, bypass}, 64'd0);
    endtask

    task automatic t_data_mode;
        apply(1, mk(1, 0, 0, 1, 8'h40, 3'd3, 16'h9999), 64'h0, 0, 1, 1, 0);
        chk("R8 hv kind", {62'd0, ctx_kind}, 64'd0);
        chk("R8 hv ctx", {48'd0, ctx}, 64'h9999);
        apply(1, mk(0, 1, 0, 0, 8'h41, 3'd3, 16'h9999), 64'h0, 0, 1, 0, 0);
        chk("R8 red kind", {62'd0, ctx_kind}, 64'd0);
        chk("R8 red real", {63'd0, real_mode}, 64'd1);
        chk("R8 red ctx", {48'd0, ctx}, 64'd0);
    endtask

    task automatic t_latency;
        apply(0, mk(0, 0, 1, 0, 8'h11, 0, 16'h1111), 64'h0, 0, 0, 0, 0);
        @(negedge clk);
        state_word = mk(0, 0, 1, 0, 8'h22, 0, 16'h2222);
        #1;
        chk("R10 holds before edge", {48'd0, ctx}, 64'h1111);
        @(posedge clk);
        @(negedge clk);
        chk("R10 updates after edge", {48'd0, ctx}, 64'h2222);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 sync reset", {56'd0, part_id}, 64'd0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_instr_bypass();
        t_instr_real();
        t_instr_mapped();
        t_data_nucleus();
        t_data_sel();
        t_data_real();
        t_data_mode();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule